// File: doc/BRIEF.md
# Floating-Point Absolute Value Unit

The unit carries out one operation: the absolute value of a 32-bit floating-point number. The mantissa is a 24-bit two's-complement field and the exponent is an 8-bit two's-complement field. The number sits in two adjacent 16-bit registers of a private 16-entry register file. An instruction word names a source pair and a destination pair. The unit reads the source pair and negates the number when it is negative. It then writes the destination pair and records a condition code for the result.

Negation is not always a plain two's complement of the mantissa. A mantissa that is the most negative 24-bit value has no positive counterpart. Such a value is turned into half of that magnitude with the exponent raised by one. When the exponent is already at its maximum, the result saturates and a sticky floating-overflow flag is raised in a pending-interrupt word. A load port and a combinational peek port give the surrounding logic access to the register file.

Top module: `fpabs_unit`

## Requirements
- R1: An instruction is accepted only when `busy` is low, `instr_valid` is high and bits 15..8 of `instr_word` equal the parameter `FABS_OPC` (default 0xA5). A word with any other value in bits 15..8 starts nothing, so `busy` and `done` stay low.
- R2: After the edge that accepts an instruction, `busy` is high for two cycles. `done` is high for exactly the second of those cycles. An instruction presented while `busy` is high is dropped.
- R3: When source mantissa bit 23 is 0, the destination pair receives the source value unchanged.
- R4: When the source mantissa is negative and not 0x800000, the result mantissa is its 24-bit two's complement and the exponent is kept.
- R5: A source mantissa of exactly 0x800000 with an exponent below 0x7F gives mantissa 0x400000 and the exponent plus one, wrapping in 8 bits (0xFF becomes 0x00).
- R6: A source mantissa of 0x800000 with exponent 0x7F gives mantissa 0x7FFFFF, exponent 0x7F, and sets bit 3 of `pi`.
- R7: `pi` bit 3 stays set until `pi_clr` is high for a cycle that does not raise it again. All other bits of `pi` are always 0.
- R8: `cs` is written together with the result. It is 0010 when the 32-bit result is zero, 0001 when bit 31 of the result is set, and 0100 otherwise.
- R9: Instruction bits 7..4 give the destination index D and bits 3..0 the source index S. Register P of a pair holds mantissa bits 23..8. Register P+1 holds mantissa bits 7..0 in its upper byte and the exponent in its lower byte. P+1 wraps modulo 16.
- R10: The source pair is read fully before the destination pair is written, so overlapping or equal source and destination pairs give the correct result.
- R11: After reset, `busy`, `done`, `cs`, `pi` and every register are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Opcode [15:8], destination [7:4], source [3:0] |
| ld_en | input | 1 | Load a register from `ld_data` |
| ld_addr | input | 4 | Register index to load |
| ld_data | input | 16 | Load value |
| peek_addr | input | 4 | Register index to read |
| peek_data | output | 16 | Combinational contents of register `peek_addr` |
| pi_clr | input | 1 | Clear the floating-overflow pending bit |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Result being written this cycle |
| cs | output | 4 | Condition status of the last result |
| pi | output | 16 | Pending-interrupt word, bit 3 = floating overflow |

## Verification
Take the edge that accepts an instruction as edge 0. `busy` is high for two cycles after it, and `done` is high only in the second. The destination pair, `cs` and `pi` hold the new values from the falling edge that follows the `done` cycle. The driver samples `busy` and `done` on the two falling edges after it presents an instruction. The monitor waits for the falling edge after `done` before it pops the expected item and reads the pair through the peek port. Dropped instructions are checked by copying the registers they would have touched in a later operation.

// File: rtl/fpabs_pkg.sv
package fpabs_pkg;

    localparam int WORD_W   = 16;
    localparam int REG_CNT  = 16;
    localparam int IDX_W    = $clog2(REG_CNT);
    localparam int MANT_W   = 24;
    localparam int EXP_W    = 8;
    localparam int OPC_W    = WORD_W - 2 * IDX_W;
    localparam int PI_W     = 16;
    localparam int PI_FOVF  = 3;
    localparam int LOW_MANT = MANT_W - WORD_W;

    localparam logic [MANT_W-1:0] MANT_MIN  = {1'b1, {(MANT_W-1){1'b0}}};
    localparam logic [MANT_W-1:0] MANT_HALF = {2'b01, {(MANT_W-2){1'b0}}};
    localparam logic [MANT_W-1:0] MANT_MAX  = {1'b0, {(MANT_W-1){1'b1}}};
    localparam logic [EXP_W-1:0]  EXP_MAX   = {1'b0, {(EXP_W-1){1'b1}}};

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
    } fpval_t;

    typedef struct packed {
        fpval_t val;
        logic   ovf;
    } absres_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
    } instr_t;

    typedef enum logic [3:0] {
        CS_NONE = 4'b0000,
        CS_NEG  = 4'b0001,
        CS_ZERO = 4'b0010,
        CS_POS  = 4'b0100
    } cs_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } st_t;

    function automatic absres_t fp_abs(input fpval_t x);
        absres_t r;
        r.val = x;
        r.ovf = 1'b0;
        if (x.mant[MANT_W-1]) begin
            if (x.mant == MANT_MIN) begin
                if (x.expo == EXP_MAX) begin
                    r.val.mant = MANT_MAX;
                    r.val.expo = EXP_MAX;
                    r.ovf      = 1'b1;
                end else begin
                    r.val.mant = MANT_HALF;
                    r.val.expo = x.expo + {{(EXP_W-1){1'b0}}, 1'b1};
                end
            end else begin
                r.val.mant = ~x.mant + {{(MANT_W-1){1'b0}}, 1'b1};
            end
        end
        return r;
    endfunction

    function automatic cs_t cs_of(input fpval_t v);
        if (v == '0)
            return CS_ZERO;
        else if (v.mant[MANT_W-1])
            return CS_NEG;
        else
            return CS_POS;
    endfunction

endpackage

// File: rtl/fpabs_regfile.sv
module fpabs_regfile #(
    parameter int W  = 16,
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_a,
    input  logic [AW-1:0] wa_a,
    input  logic [W-1:0]  wd_a,
    input  logic          we_b,
    input  logic [AW-1:0] wa_b,
    input  logic [W-1:0]  wd_b,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_c,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_c
);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)
                mem[i] <= '0;
            else if (we_a && wa_a == AW'(i))
                mem[i] <= wd_a;
            else if (we_b && wa_b == AW'(i))
                mem[i] <= wd_b;
            else if (ld_en && ld_addr == AW'(i))
                mem[i] <= ld_data;
        end
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    assign rd_c = mem[ra_c];

endmodule

// File: rtl/fpabs_ctrl.sv
module fpabs_ctrl
    import fpabs_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC = 8'hA5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  instr_t           instr,
    output logic             busy,
    output logic             done,
    output logic             cap_en,
    output logic [IDX_W-1:0] src_idx,
    output logic [IDX_W-1:0] dst_idx
);

    st_t              state;
    logic [IDX_W-1:0] src_q;
    logic [IDX_W-1:0] dst_q;
    logic             take;

    assign take = (state == ST_IDLE) && instr_valid && (instr.opc == OPC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE:  if (take) begin
                    state <= ST_READ;
                    src_q <= instr.src;
                    dst_q <= instr.dst;
                end
                ST_READ:  state <= ST_WRITE;
                ST_WRITE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_WRITE);
    assign cap_en  = (state == ST_READ);
    assign src_idx = src_q;
    assign dst_idx = dst_q;

endmodule

// File: rtl/fpabs_status.sv
module fpabs_status
    import fpabs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  absres_t         res,
    input  logic            pi_clr,
    output logic [3:0]      cs,
    output logic [PI_W-1:0] pi
);

    cs_t  cs_q;
    logic fovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= CS_NONE;
            fovf_q <= 1'b0;
        end else begin
            if (upd)
                cs_q <= cs_of(res.val);
            if (upd && res.ovf)
                fovf_q <= 1'b1;
            else if (pi_clr)
                fovf_q <= 1'b0;
        end
    end

    assign cs = cs_q;

    always_comb begin
        pi          = '0;
        pi[PI_FOVF] = fovf_q;
    end

endmodule

// File: rtl/fpabs_unit.sv
module fpabs_unit
    import fpabs_pkg::*;
#(
    parameter logic [OPC_W-1:0] FABS_OPC = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  peek_addr,
    output logic [WORD_W-1:0] peek_data,
    input  logic              pi_clr,
    output logic              busy,
    output logic              done,
    output logic [3:0]        cs,
    output logic [PI_W-1:0]   pi
);

    localparam logic [IDX_W-1:0] ONE_IDX = {{(IDX_W-1){1'b0}}, 1'b1};

    logic              cap_en;
    logic [IDX_W-1:0]  src_idx;
    logic [IDX_W-1:0]  dst_idx;
    logic [WORD_W-1:0] src_hi;
    logic [WORD_W-1:0] src_lo;
    fpval_t            op_q;
    absres_t           res;

    fpabs_ctrl #(.OPC(FABS_OPC)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr       (instr_t'(instr_word)),
        .busy        (busy),
        .done        (done),
        .cap_en      (cap_en),
        .src_idx     (src_idx),
        .dst_idx     (dst_idx)
    );

    fpabs_regfile #(.W(WORD_W), .N(REG_CNT), .AW(IDX_W)) rf_i (
        .clk     (clk),
        .rst     (rst),
        .we_a    (done),
        .wa_a    (dst_idx),
        .wd_a    (res.val.mant[MANT_W-1 -: WORD_W]),
        .we_b    (done),
        .wa_b    (dst_idx + ONE_IDX),
        .wd_b    ({res.val.mant[LOW_MANT-1:0], res.val.expo}),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .ra_a    (src_idx),
        .ra_b    (src_idx + ONE_IDX),
        .ra_c    (peek_addr),
        .rd_a    (src_hi),
        .rd_b    (src_lo),
        .rd_c    (peek_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            op_q <= '0;
        else if (cap_en)
            op_q <= {src_hi, src_lo};
    end

    assign res = fp_abs(op_q);

    fpabs_status status_i (
        .clk    (clk),
        .rst    (rst),
        .upd    (done),
        .res    (res),
        .pi_clr (pi_clr),
        .cs     (cs),
        .pi     (pi)
    );

endmodule

// File: rtl/fpabs_unit_chk.sv
module fpabs_unit_chk
    import fpabs_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC = 8'hA5
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [WORD_W-1:0] instr_word,
    input logic              pi_clr,
    input logic              busy,
    input logic              done,
    input logic [3:0]        cs,
    input logic [PI_W-1:0]   pi
);

    logic good_opc;
    assign good_opc = (instr_word[WORD_W-1 -: OPC_W] == OPC);

    AST_BAD_OPC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!busy && instr_valid && !good_opc) |=> !busy);                         // R1
    AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        (!busy && instr_valid && good_opc) |=> (busy && !done) ##1 done);       // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                        // R2
    AST_OVF_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(pi[PI_FOVF]) |-> $past(done));                                    // R6
    AST_PI_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pi[PI_FOVF] && !pi_clr) |=> pi[PI_FOVF]);                              // R7
    AST_PI_ONLY_FOVF: assert property (@(posedge clk) disable iff (rst)
        $countones(pi) == $countones(pi[PI_FOVF]));                             // R7
    AST_CS_ONE_CODE: assert property (@(posedge clk) disable iff (rst)
        done |=> $onehot(cs));                                                  // R8

endmodule

bind fpabs_unit fpabs_unit_chk #(.OPC(FABS_OPC)) chk_i (.*);

// File: tb/fpabs_unit_tb_top.sv
`timescale 1ns/1ps
module fpabs_unit_tb_top;

    localparam logic [7:0] OPC = 8'hA5;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic        ld_en;
    logic [3:0]  ld_addr;
    logic [15:0] ld_data;
    logic [3:0]  peek_addr;
    logic [15:0] peek_data;
    logic        pi_clr;
    logic        busy;
    logic        done;
    logic [3:0]  cs;
    logic [15:0] pi;

    always #2.5 clk = ~clk;

    fpabs_unit #(.FABS_OPC(OPC)) dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data), .pi_clr(pi_clr),
        .busy(busy), .done(done), .cs(cs), .pi(pi)
    );

    typedef struct {
        logic [3:0]  ra;
        logic [15:0] hi;
        logic [15:0] lo;
        logic [3:0]  cs;
        logic        pi3;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    logic [15:0] mir [16];
    logic        exp_pi3;
    int          n_run;
    int          n_fail;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic model(input logic [15:0] hi, input logic [15:0] lo,
                         output logic [15:0] rhi, output logic [15:0] rlo,
                         output logic ovf);
        logic [23:0] m;
        logic [7:0]  e;
        m   = {hi, lo[15:8]};
        e   = lo[7:0];
        ovf = 1'b0;
        if (m[23]) begin
            if (m == 24'h800000) begin
                if (e == 8'h7F) begin
                    m = 24'h7FFFFF; ovf = 1'b1;
                end else begin
                    m = 24'h400000; e = e + 8'd1;
                end
            end else begin
                m = 24'd0 - m;
            end
        end
        rhi = m[23:8];
        rlo = {m[7:0], e};
    endtask

    task automatic load(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        mir[a] = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic expect_op(input logic [3:0] ra, input logic [3:0] rb, input string req);
        exp_t        e;
        logic [15:0] rhi, rlo;
        logic        ovf;
        model(mir[rb], mir[4'(rb + 4'd1)], rhi, rlo, ovf);
        mir[ra]            = rhi;
        mir[4'(ra + 4'd1)] = rlo;
        if (ovf) exp_pi3 = 1'b1;
        e.ra  = ra;
        e.hi  = rhi;
        e.lo  = rlo;
        e.cs  = ({rhi, rlo} == 32'd0) ? 4'b0010 : (rhi[15] ? 4'b0001 : 4'b0100);
        e.pi3 = exp_pi3;
        e.req = req;
        sbq.push_back(e);
    endtask

    task automatic issue(input logic [3:0] ra, input logic [3:0] rb, input string req);
        @(negedge clk);
        while (busy) @(negedge clk);
        expect_op(ra, rb, req);
        instr_valid = 1'b1;
        instr_word  = {OPC, ra, rb};
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R2", "busy in read cycle", {31'd0, busy}, 32'd1);
        chk("R2", "done in read cycle", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R2", "done in write cycle", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk("R2", "done after write", {31'd0, done}, 32'd0);
        @(negedge clk);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (done === 1'b1) begin
                @(negedge clk);
                if (sbq.size() == 0) begin
                    chk("R2", "unexpected result", 32'd1, 32'd0);
                end else begin
                    e = sbq.pop_front();
                    peek_addr = e.ra;
                    #1;
                    chk(e.req, "dest hi", {16'd0, peek_data}, {16'd0, e.hi});
                    peek_addr = 4'(e.ra + 4'd1);
                    #1;
                    chk(e.req, "dest lo", {16'd0, peek_data}, {16'd0, e.lo});
                    chk("R8", "cs", {28'd0, cs}, {28'd0, e.cs});
                    chk("R7", "pi", {16'd0, pi}, {28'd0, e.pi3, 3'b000});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : driver
        n_run = 0; n_fail = 0; exp_pi3 = 1'b0;
        for (int i = 0; i < 16; i++) mir[i] = 16'h0000;
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
        ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        peek_addr = '0; pi_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R11", "done after reset", {31'd0, done}, 32'd0);
        chk("R11", "cs after reset", {28'd0, cs}, 32'd0);
        chk("R11", "pi after reset", {16'd0, pi}, 32'd0);

        // R11 registers are zero; R8 zero code
        issue(4'd2, 4'd0, "R11");
        // R3 positive copy, R9 layout
        load(4'd4, 16'h4000); load(4'd5, 16'h0003);
        issue(4'd6, 4'd4, "R3");
        // R8 positive with zero mantissa but nonzero exponent
        load(4'd8, 16'h0000); load(4'd9, 16'h0005);
        issue(4'd10, 4'd8, "R8");
        // R4 general negation
        load(4'd4, 16'hA000); load(4'd5, 16'h0005);
        issue(4'd6, 4'd4, "R4");
        load(4'd4, 16'hC000); load(4'd5, 16'h01FE);
        issue(4'd6, 4'd4, "R4");
        // R5 power-of-two renormalise, including exponent wrap
        load(4'd4, 16'h8000); load(4'd5, 16'h0002);
        issue(4'd6, 4'd4, "R5");
        load(4'd5, 16'h00FF);
        issue(4'd6, 4'd4, "R5");
        // R6 overflow saturation
        load(4'd5, 16'h007F);
        issue(4'd6, 4'd4, "R6");
        // R7 sticky through a normal operation
        load(4'd4, 16'h2000); load(4'd5, 16'h0001);
        issue(4'd6, 4'd4, "R7");
        @(negedge clk);
        pi_clr = 1'b1;
        @(negedge clk);
        pi_clr = 1'b0;
        exp_pi3 = 1'b0;
        chk("R7", "pi after clear", {16'd0, pi}, 32'd0);
        // R9 wrap of source and destination index
        load(4'd15, 16'hB000); load(4'd0, 16'h0010);
        issue(4'd15, 4'd15, "R9");
        issue(4'd14, 4'd15, "R9");
        // R10 in place and overlapping
        load(4'd8, 16'h9000); load(4'd9, 16'h3407);
        issue(4'd8, 4'd8, "R10");
        load(4'd8, 16'hE000); load(4'd9, 16'h1102);
        issue(4'd9, 4'd8, "R10");
        load(4'd8, 16'hD000); load(4'd9, 16'h2203);
        issue(4'd7, 4'd8, "R10");
        // R1 wrong opcode is dropped
        load(4'd4, 16'h9000); load(4'd5, 16'h0001);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = {8'h00, 4'd11, 4'd4};
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R1", "busy after bad opcode", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R1", "done after bad opcode", {31'd0, done}, 32'd0);
        issue(4'd2, 4'd11, "R1");
        // R2 instruction presented while busy is dropped
        @(negedge clk);
        expect_op(4'd6, 4'd4, "R2");
        instr_valid = 1'b1; instr_word = {OPC, 4'd6, 4'd4};
        @(negedge clk);
        instr_word = {OPC, 4'd12, 4'd4};
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (4) @(negedge clk);
        issue(4'd2, 4'd12, "R2");

        repeat (3) @(negedge clk);
        chk("R2", "scoreboard drained", sbq.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule